// File: doc/BRIEF.md
# Modem line edge detector

This block watches the four modem-status inputs of a serial port (clear-to-send, carrier detect, data-set-ready and ring indicator) and drives the two modem-control outputs (request-to-send and data-terminal-ready). Each input passes through a synchronizer. The block then reports the line levels in a status word. Changes on clear-to-send and carrier detect latch per-line pending flags. A single change-interrupt request goes to the port's main interrupt logic.

Software configures the block through one control word. This word holds the two output requests, a loopback enable, a per-line interrupt enable and a per-line both-edges selector. The output pins carry the inverse of the requested values. The status word is read with a one-cycle read strobe, and that read acknowledges all pending change flags.

Top module: `modem_line_watch`

## Requirements
- R1: Status bits report synchronized line levels with ring indicator in bit 0, clear-to-send in bit 1, carrier detect in bit 2 and data-set-ready in bit 3. A change on an input appears there after the second rising clock edge that samples it (SYNC_STAGES = 2).
- R2: With its both-edges selector clear, a line sets its pending bit only on a rising synchronized level. Clear-to-send pending is status bit 4 and carrier-detect pending is status bit 5. The bit is set one clock after the new level appears in the status word. A falling level does not set it.
- R3: With its both-edges selector set (control bit 5 for clear-to-send, bit 6 for carrier detect), both rising and falling synchronized levels set the pending bit.
- R4: Changes on data-set-ready and ring indicator never set any pending bit.
- R5: A cycle with `stat_re` high clears both pending bits at that clock edge. A change detected at that same edge still sets its pending bit.
- R6: `rts_n` equals the inverse of control bit 0, and `dtr_n` equals the inverse of control bit 1.
- R7: `loop_en` follows control bit 2.
- R8: `chg_irq` is high when clear-to-send pending is set with control bit 3 set, or when carrier-detect pending is set with control bit 4 set. It stays high until a read clears the pending bits or the enables are removed.
- R9: After reset, the control word is zero, both pending bits are clear, `rts_n` and `dtr_n` are high, and `chg_irq` and `loop_en` are low.
- R10: A cycle with `ctl_we` high loads `ctl_wdata` into the control word at that edge. `ctl_rdata` returns the control word, which holds its value while `ctl_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| stat_re | input | 1 | Status read strobe; acknowledges pending bits |
| stat_rdata | output | 6 | Levels in bits 3:0, pending flags in bits 5:4 |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word write data |
| ctl_rdata | output | 7 | Control word readback |
| rts_n | output | 1 | Request-to-send pin, inverted |
| dtr_n | output | 1 | Data-terminal-ready pin, inverted |
| loop_en | output | 1 | Loopback enable to the serial datapath |
| chg_irq | output | 1 | Modem-line change interrupt request |

## Verification
A corrupted synchronizer or previous-level register shows up in the status level bits within one or two cycles. It can also cause a spurious pending flag, and with it an interrupt, on the following edge. A pending flag that is lost or stuck becomes visible in status bits 5:4 and on `chg_irq` on the cycle after the edge or read that should have changed it. Control-word errors show up at once on the inverted pins, the loopback output and the readback. The reference model is compared against every output field on every cycle, so any of these deviations is reported in the first cycle it reaches a port.

// File: rtl/modem_line_watch.sv
module modem_line_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ri_in,
  input  logic       cts_in,
  input  logic       dcd_in,
  input  logic       dsr_in,
  input  logic       stat_re,
  output logic [5:0] stat_rdata,
  input  logic       ctl_we,
  input  logic [6:0] ctl_wdata,
  output logic [6:0] ctl_rdata,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       loop_en,
  output logic       chg_irq
);
  localparam int NLINE  = 4;
  localparam int CTL_W  = 7;
  localparam int L_CTS  = 1;
  localparam int L_DCD  = 2;
  localparam int C_RTS  = 0;
  localparam int C_DTR  = 1;
  localparam int C_LOOP = 2;
  localparam int C_CIE  = 3;
  localparam int C_DIE  = 4;
  localparam int C_CANY = 5;
  localparam int C_DANY = 6;

  logic [NLINE-1:0] raw, lvl, prev_q, delta, rise;
  logic [CTL_W-1:0] ctl_q;
  logic             cts_pend, dcd_pend, cts_hit, dcd_hit;

  assign raw = {dsr_in, dcd_in, cts_in, ri_in};

  for (genvar i = 0; i < NLINE; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], raw[i]};
    assign lvl[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;

  assign delta   = lvl ^ prev_q;
  assign rise    = lvl & ~prev_q;
  assign cts_hit = ctl_q[C_CANY] ? delta[L_CTS] : rise[L_CTS];
  assign dcd_hit = ctl_q[C_DANY] ? delta[L_DCD] : rise[L_DCD];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_pend <= 1'b0;
      dcd_pend <= 1'b0;
    end else begin
      cts_pend <= (cts_pend & ~stat_re) | cts_hit;
      dcd_pend <= (dcd_pend & ~stat_re) | dcd_hit;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;

  assign stat_rdata = {dcd_pend, cts_pend, lvl};
  assign ctl_rdata  = ctl_q;
  assign rts_n      = ~ctl_q[C_RTS];
  assign dtr_n      = ~ctl_q[C_DTR];
  assign loop_en    = ctl_q[C_LOOP];
  assign chg_irq    = (cts_pend & ctl_q[C_CIE]) | (dcd_pend & ctl_q[C_DIE]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && !cts_hit && !dcd_hit) |=> (!cts_pend && !dcd_pend));

  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_re && cts_pend) |=> cts_pend);

  assert_pend_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dcd_pend) |-> $past(lvl[L_DCD] != prev_q[L_DCD]));

  assert_both_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[C_CANY] && lvl[L_CTS] != prev_q[L_CTS]) |=> cts_pend);

  assert_ctl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata));
endmodule

// File: tb/sim_modem_line_watch.sv
module sim_modem_line_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ri_in = 0, cts_in = 0, dcd_in = 0, dsr_in = 0;
  logic       stat_re = 0, ctl_we = 0;
  logic [6:0] ctl_wdata = '0;
  logic [5:0] stat_rdata;
  logic [6:0] ctl_rdata;
  logic       rts_n, dtr_n, loop_en, chg_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [3:0] h0 = '0, h1 = '0, h2 = '0;
  logic       mc = 0, md = 0;
  logic [6:0] mctl = '0;

  always #4 clk = ~clk;

  modem_line_watch u0 (
    .clk(clk), .rst_n(rst_n), .ri_in(ri_in), .cts_in(cts_in), .dcd_in(dcd_in),
    .dsr_in(dsr_in), .stat_re(stat_re), .stat_rdata(stat_rdata), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .rts_n(rts_n), .dtr_n(dtr_n),
    .loop_en(loop_en), .chg_irq(chg_irq));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 levels", stat_rdata[3:0], h1);
    chk("R2/R3/R4/R5 cts pending", stat_rdata[4], mc);
    chk("R2/R3/R4/R5 dcd pending", stat_rdata[5], md);
    chk("R6 rts_n", rts_n, !mctl[0]);
    chk("R6 dtr_n", dtr_n, !mctl[1]);
    chk("R7 loop_en", loop_en, mctl[2]);
    chk("R8 chg_irq", chg_irq, (mc & mctl[3]) | (md & mctl[4]));
    chk("R10 ctl readback", ctl_rdata, mctl);
  endtask

  task automatic step(input logic [3:0] lines, input logic re, input logic we,
                      input logic [6:0] wd);
    logic hc, hd;
    {dsr_in, dcd_in, cts_in, ri_in} = lines;
    stat_re = re; ctl_we = we; ctl_wdata = wd;
    @(posedge clk);
    hc = mctl[5] ? (h1[1] != h2[1]) : (h1[1] && !h2[1]);
    hd = mctl[6] ? (h1[2] != h2[2]) : (h1[2] && !h2[2]);
    mc = (mc & !re) | hc;
    md = (md & !re) | hd;
    h2 = h1; h1 = h0; h0 = lines;
    if (we) mctl = wd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic hold(input logic [3:0] lines, input int n);
    for (int k = 0; k < n; k++) step(lines, 1'b0, 1'b0, mctl);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R9 reset rts_n", rts_n, 1);
    chk("R9 reset dtr_n", dtr_n, 1);
    chk("R9 reset irq", chg_irq, 0);
    chk("R9 reset loop", loop_en, 0);
    chk("R9 reset status", stat_rdata, 0);
    chk("R9 reset ctl", ctl_rdata, 0);
    rst_n = 1'b1;
    hold(4'b0000, 3);
    // R6 R7 R10: drive control outputs
    step(4'b0000, 0, 1, 7'b0000101);
    step(4'b0000, 0, 1, 7'b0000010);
    step(4'b0000, 0, 1, 7'b0011000);
    // R2: cts rise sets pending, R8 irq
    hold(4'b0010, 5);
    step(4'b0010, 1, 0, mctl);           // R5 read clears
    hold(4'b0000, 5);                    // R2 falling ignored
    // R4: dsr and ri toggles
    hold(4'b1001, 5);
    hold(4'b0000, 5);
    // R3: both edges on both lines
    step(4'b0000, 0, 1, 7'b1111000);
    hold(4'b0110, 5);
    step(4'b0110, 1, 0, mctl);
    hold(4'b0000, 5);
    step(4'b0000, 1, 0, mctl);
    // R5: read on the same edge as a detected change
    hold(4'b0010, 3);
    step(4'b0010, 1, 0, mctl);
    hold(4'b0000, 2);
    step(4'b0000, 1, 0, mctl);
    hold(4'b0000, 3);
    // R8: enables removed drop irq, pending remains
    hold(4'b0100, 4);
    step(4'b0100, 0, 1, 7'b1100000);
    hold(4'b0100, 2);
    step(4'b0100, 0, 1, 7'b0011011);
    hold(4'b0100, 2);
    // mixed stimulus
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0] & {4{lf[9]}} | (h0 & {4{!lf[9]}}), lf[6] & lf[7],
           lf[11] & lf[12] & lf[13], lf[15:9]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule